// File: doc/BRIEF.md
# Low-Power Wake-up and Interrupt Dispatcher

This block sits beside the core of a small 8-bit microcontroller. It keeps track of the operating mode: run (the core executes), idle (the core is stopped while the main oscillator and timers keep going) or sleep (the main oscillator and timers are halted). It watches single-cycle event strobes from three maskable sources and from the watchdog. For each source, a wake-enable bit and an interrupt-enable bit are combined with the global interrupt enable. From these the block decides four things: whether the part leaves a low-power mode, whether the source's pending flag is set, whether the core resumes at the next instruction or is redirected to the interrupt vector, and whether a reset is forced.

The core enters idle or sleep through a mode request. It clears pending flags through a clear strobe, which is a write of 0 to the flag. The clock controller sees a one-cycle wake strobe and a clock-run level, and that level is low only in sleep. The program-counter logic sees a one-cycle redirect strobe with a target address. The target is 0x08 for an interrupt and 0x00 for a watchdog reset. Every decision is registered, so every output responds one clock after the inputs that cause it.

Top module: `pwr_event_dispatch`

## Requirements
- R1: After reset the mode is run (encoding 0), clk_run is 1, all pending flags are 0 and wake_pulse, redir_pulse and redir_is_rst are 0.
- R2: In run mode, a mode request with code 1 (idle) or 2 (sleep) moves the mode there on the next cycle. Code 0 or 3 is ignored, a request made outside run mode is ignored, and a request made in a cycle that issues a redirect is ignored. clk_run is 0 exactly when the mode is sleep (2).
- R3: An event on a source whose interrupt enable is 1 sets that source's pending flag on the next cycle, in any mode and whatever its wake enable. With interrupt enable 0, the flag is left unchanged. Bit order on all per-source buses: 0 ADC done, 1 PWM period match, 2 comparator change.
- R4: A pending flag stays set until its clear strobe. A set and a clear in the same cycle leave the flag set.
- R5: In idle or sleep, an event from a source that can wake in that mode and has wake enable 1 returns the mode to run on the next cycle and raises wake_pulse for exactly one cycle. If its interrupt enable or the global enable is 0, no redirect is issued and the core continues at the next instruction.
- R6: A wake as in R5 with interrupt enable 1 and global enable 1 also raises redir_pulse for one cycle with redir_addr 0x08 and redir_is_rst 0.
- R7: In idle or sleep, an event with wake enable 0 neither changes the mode nor produces a wake or a redirect.
- R8: The PWM source cannot wake the part from sleep but can wake it from idle. The ADC and comparator sources can wake it from both.
- R9: In run mode, an event with interrupt enable 1 issues a vector redirect (0x08) when the global enable is 1 and no redirect when it is 0.
- R10: A watchdog timeout with watchdog enable 1 issues redir_pulse with redir_addr 0x00 and redir_is_rst 1 in any mode. In idle or sleep it also wakes the part. With watchdog enable 0 the timeout has no effect.
- R11: When several events arrive in one cycle, all qualifying flags are latched together and exactly one redirect strobe is issued. A watchdog reset takes precedence over the vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_req_vld | input | 1 | Core requests a low-power mode this cycle |
| mode_req | input | 2 | Requested mode: 1 idle, 2 sleep |
| gie | input | 1 | Global interrupt enable |
| src_evt | input | NSRC | Event strobes per source |
| src_wake_en | input | NSRC | Wake enable per source |
| src_irq_en | input | NSRC | Interrupt enable per source |
| flag_clr | input | NSRC | Pending flag clear strobes |
| wdt_en | input | 1 | Watchdog enable |
| wdt_tmo | input | 1 | Watchdog timeout strobe |
| mode | output | 2 | Current mode: 0 run, 1 idle, 2 sleep |
| clk_run | output | 1 | Main oscillator and timer run enable |
| wake_pulse | output | 1 | One-cycle wake request to the clock controller |
| pend | output | NSRC | Pending flags |
| redir_pulse | output | 1 | One-cycle program-counter redirect request |
| redir_addr | output | PC_W | Redirect target |
| redir_is_rst | output | 1 | Redirect is a watchdog reset |

## Verification
The bench builds the block with its defaults: three sources, 8-bit targets, every source allowed to wake from idle, and only the ADC and comparator sources allowed to wake from sleep. That configuration puts the sleep-only block on the PWM source within reach, so the same event can be shown to wake the part from idle and not from sleep. Directed sequences cover each mode against every combination of wake enable, interrupt enable and global enable, followed by a long random phase. The random phase stacks simultaneous events, clears and watchdog timeouts, and the model's one-redirect and reset-first rules must decide the outcome of each of those cycles.

// File: rtl/pwr_evt_pkg.sv
// Shared types for the wake/interrupt dispatcher.
// Assumes: the mode encoding is visible at the top port, so values are fixed.
package pwr_evt_pkg;
    typedef enum logic [1:0] {
        PM_RUN   = 2'd0,
        PM_IDLE  = 2'd1,
        PM_SLEEP = 2'd2
    } pmode_t;
endpackage

// File: rtl/pwr_evt_lane.sv
// One source's decision slice: combines its event with its enables and the
// current mode into three votes (set flag, wake, ask for the vector).
// Assumes: evt is a single-cycle strobe; the vote is gated later by the mode FSM.
module pwr_evt_lane
    import pwr_evt_pkg::*;
#(
    parameter bit CAN_IDLE  = 1'b1,
    parameter bit CAN_SLEEP = 1'b1
) (
    input  pmode_t mode,
    input  logic   evt,
    input  logic   wake_en,
    input  logic   irq_en,
    input  logic   gie,
    output logic   set_flag,
    output logic   wake,
    output logic   ask_vec
);
    logic wake_ok;

    // Purpose: can this source end the present low-power mode at all.
    always_comb begin
        unique case (mode)
            PM_IDLE:  wake_ok = CAN_IDLE;
            PM_SLEEP: wake_ok = CAN_SLEEP;
            default:  wake_ok = 1'b0;
        endcase
    end

    // Purpose: produce the three per-source votes.
    always_comb begin
        set_flag = evt & irq_en;
        wake     = evt & wake_en & wake_ok;
        ask_vec  = evt & irq_en & gie;
    end
endmodule

// File: rtl/pwr_pend_bank.sv
// Pending flag register bank: set by qualified events, cleared by core writes.
// Assumes: set wins over a same-cycle clear.
module pwr_pend_bank #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] pend
);
    logic past_ok;

    // Purpose: hold, clear and set the flags.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= (pend & ~clr) | set;
    end

    // Purpose: marks that one cycle of history exists since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    for (genvar i = 0; i < N; i++) begin : g_chk
        // R4: an uncleared flag stays set
        a_r4_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (pend[i] && !clr[i]) |=> pend[i]);
        // R3: a qualified event always shows up as a set flag
        a_r3_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
            (past_ok && $past(set[i])) |-> pend[i]);
    end
endmodule

// File: rtl/pwr_mode_fsm.sv
// Mode register and redirect generator. It leaves low power on any wake or
// watchdog hit, accepts low-power entry requests only in run mode, and issues
// at most one redirect per cycle, with the reset ahead of the vector.
// Assumes: all vote inputs are already reduced over the sources.
module pwr_mode_fsm
    import pwr_evt_pkg::*;
#(
    parameter int              PC_W     = 8,
    parameter logic [PC_W-1:0] VEC_ADDR = 8'h08,
    parameter logic [PC_W-1:0] RST_ADDR = 8'h00
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            any_wake,
    input  logic            any_vec,
    input  logic            wdt_hit,
    input  logic            req_vld,
    input  logic [1:0]      req_mode,
    output pmode_t          mode,
    output logic            wake_pulse,
    output logic            redir_pulse,
    output logic [PC_W-1:0] redir_addr,
    output logic            redir_is_rst
);
    logic   low_pwr, leave, running, do_rst, do_vec, req_ok, past_ok;
    pmode_t mode_nx;

    // Purpose: work out the outcome of this cycle.
    always_comb begin
        low_pwr = (mode != PM_RUN);
        leave   = low_pwr & (any_wake | wdt_hit);
        running = ~low_pwr | leave;
        do_rst  = wdt_hit;
        do_vec  = ~wdt_hit & any_vec & running;
        req_ok  = req_vld & ((req_mode == 2'd1) | (req_mode == 2'd2))
                  & ~low_pwr & ~do_rst & ~do_vec;
        if (leave)       mode_nx = PM_RUN;
        else if (req_ok) mode_nx = pmode_t'(req_mode);
        else             mode_nx = mode;
    end

    // Purpose: register the mode and the one-cycle strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode         <= PM_RUN;
            wake_pulse   <= 1'b0;
            redir_pulse  <= 1'b0;
            redir_addr   <= '0;
            redir_is_rst <= 1'b0;
        end else begin
            mode         <= mode_nx;
            wake_pulse   <= leave;
            redir_pulse  <= do_rst | do_vec;
            redir_addr   <= do_rst ? RST_ADDR : (do_vec ? VEC_ADDR : '0);
            redir_is_rst <= do_rst;
        end
    end

    // Purpose: marks that one cycle of history exists since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R5: the wake strobe lasts a single cycle
    a_r5_wake_single: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |=> !wake_pulse);
    // R5: every return to run mode is announced by the wake strobe
    a_r5_exit_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && mode == PM_RUN && $past(mode) != PM_RUN) |-> wake_pulse);
    // R10: a watchdog hit always yields a reset redirect to the reset address
    a_r10_wdt_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(wdt_hit)) |-> (redir_pulse && redir_is_rst && redir_addr == RST_ADDR));
    // R2: entry to a low-power mode only ever starts from run mode
    a_r2_entry_from_run: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && mode != PM_RUN && $past(mode) != mode) |-> ($past(mode) == PM_RUN));
endmodule

// File: rtl/pwr_event_dispatch.sv
// Top of the wake-up and interrupt dispatcher. One decision lane per
// maskable source (generate), reduced into the mode FSM and the flag bank.
// Assumes: source 0 ADC done, 1 PWM period match, 2 comparator change.
module pwr_event_dispatch
    import pwr_evt_pkg::*;
#(
    parameter int                NSRC        = 3,
    parameter int                PC_W        = 8,
    parameter logic [NSRC-1:0]   IDLE_WAKE   = 3'b111,
    parameter logic [NSRC-1:0]   SLEEP_WAKE  = 3'b101,
    parameter logic [PC_W-1:0]   VEC_ADDR    = 8'h08,
    parameter logic [PC_W-1:0]   RST_ADDR    = 8'h00
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mode_req_vld,
    input  logic [1:0]      mode_req,
    input  logic            gie,
    input  logic [NSRC-1:0] src_evt,
    input  logic [NSRC-1:0] src_wake_en,
    input  logic [NSRC-1:0] src_irq_en,
    input  logic [NSRC-1:0] flag_clr,
    input  logic            wdt_en,
    input  logic            wdt_tmo,
    output logic [1:0]      mode,
    output logic            clk_run,
    output logic            wake_pulse,
    output logic [NSRC-1:0] pend,
    output logic            redir_pulse,
    output logic [PC_W-1:0] redir_addr,
    output logic            redir_is_rst
);
    pmode_t          mode_q;
    logic [NSRC-1:0] v_set, v_wake, v_vec;
    logic            wdt_hit, past_ok;

    for (genvar i = 0; i < NSRC; i++) begin : g_lane
        pwr_evt_lane #(
            .CAN_IDLE  (IDLE_WAKE[i]),
            .CAN_SLEEP (SLEEP_WAKE[i])
        ) u_lane (
            .mode     (mode_q),
            .evt      (src_evt[i]),
            .wake_en  (src_wake_en[i]),
            .irq_en   (src_irq_en[i]),
            .gie      (gie),
            .set_flag (v_set[i]),
            .wake     (v_wake[i]),
            .ask_vec  (v_vec[i])
        );
    end

    // Purpose: qualify the watchdog strobe.
    always_comb wdt_hit = wdt_en & wdt_tmo;

    pwr_mode_fsm #(
        .PC_W     (PC_W),
        .VEC_ADDR (VEC_ADDR),
        .RST_ADDR (RST_ADDR)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .any_wake     (|v_wake),
        .any_vec      (|v_vec),
        .wdt_hit      (wdt_hit),
        .req_vld      (mode_req_vld),
        .req_mode     (mode_req),
        .mode         (mode_q),
        .wake_pulse   (wake_pulse),
        .redir_pulse  (redir_pulse),
        .redir_addr   (redir_addr),
        .redir_is_rst (redir_is_rst)
    );

    pwr_pend_bank #(.N(NSRC)) u_pend (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (v_set),
        .clr   (flag_clr),
        .pend  (pend)
    );

    // Purpose: expose the mode and derive the main clock run level.
    always_comb begin
        mode    = mode_q;
        clk_run = (mode_q != PM_SLEEP);
    end

    // Purpose: marks that one cycle of history exists since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R9: a vector redirect needs the global enable in the cycle before
    a_r9_vec_needs_gie: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && redir_pulse && !redir_is_rst) |-> $past(gie));
    // R7: with no wake enable on any event source and no watchdog, low power holds
    a_r7_no_wake_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != PM_RUN && (src_evt & src_wake_en) == '0 && !wdt_hit) |=> $stable(mode_q));
endmodule

// File: tb/pwr_event_dispatch_bench.sv
`timescale 1ns/1ps
module pwr_event_dispatch_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       mode_req_vld;
    logic [1:0] mode_req;
    logic       gie;
    logic [2:0] src_evt, src_wake_en, src_irq_en, flag_clr;
    logic       wdt_en, wdt_tmo;
    logic [1:0] mode;
    logic       clk_run, wake_pulse, redir_pulse, redir_is_rst;
    logic [2:0] pend;
    logic [7:0] redir_addr;

    int total = 0;
    int bad   = 0;

    // behavioural reference state
    int       m_mode;
    bit [2:0] m_pend;
    bit       m_wake, m_redir, m_rst;
    int       m_addr;

    always #2 clk = ~clk;

    pwr_event_dispatch u_pwr_event_dispatch (
        .clk(clk), .rst_n(rst_n), .mode_req_vld(mode_req_vld), .mode_req(mode_req),
        .gie(gie), .src_evt(src_evt), .src_wake_en(src_wake_en), .src_irq_en(src_irq_en),
        .flag_clr(flag_clr), .wdt_en(wdt_en), .wdt_tmo(wdt_tmo), .mode(mode),
        .clk_run(clk_run), .wake_pulse(wake_pulse), .pend(pend), .redir_pulse(redir_pulse),
        .redir_addr(redir_addr), .redir_is_rst(redir_is_rst)
    );

    task automatic chk(input string tag, input string what, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: %s got %0d exp %0d", tag, what, got, exp);
        end
    endtask

    // one reference step from the inputs sampled at a rising edge
    task automatic model_step();
        bit woke, vec, hit, low, run;
        bit [2:0] np;
        if (!rst_n) begin
            m_mode = 0; m_pend = 0; m_wake = 0; m_redir = 0; m_rst = 0; m_addr = 0;
            return;
        end
        hit = wdt_en && wdt_tmo;
        low = (m_mode != 0);
        woke = 0; vec = 0;
        np = m_pend & ~flag_clr;
        for (int i = 0; i < 3; i++) begin
            if (src_evt[i] && src_irq_en[i]) np[i] = 1;
            if (low && src_evt[i] && src_wake_en[i] && !(m_mode == 2 && i == 1)) woke = 1;
        end
        if (hit && low) woke = 1;
        run = !low || woke;
        if (!hit && run)
            for (int i = 0; i < 3; i++)
                if (src_evt[i] && src_irq_en[i] && gie) vec = 1;
        m_pend  = np;
        m_wake  = low && woke;
        m_redir = hit || vec;
        m_rst   = hit;
        m_addr  = hit ? 0 : (vec ? 8 : 0);
        if (low && woke) m_mode = 0;
        else if (!low && mode_req_vld && (mode_req == 1 || mode_req == 2) && !hit && !vec)
            m_mode = mode_req;
    endtask

    // advance one clock, update the model, compare at the falling edge
    task automatic tick(input string tag);
        @(posedge clk);
        model_step();
        @(negedge clk);
        chk({tag, " [R2 mode]"}, "mode", mode, m_mode);
        chk({tag, " [R2 clk_run]"}, "clk_run", clk_run, m_mode != 2);
        chk({tag, " [R3 R4 pend]"}, "pend", pend, m_pend);
        chk({tag, " [R5 wake]"}, "wake_pulse", wake_pulse, m_wake);
        chk({tag, " [R6 R9 redir]"}, "redir_pulse", redir_pulse, m_redir);
        chk({tag, " [R10 addr]"}, "redir_addr", redir_addr, m_addr);
        chk({tag, " [R10 rst]"}, "redir_is_rst", redir_is_rst, m_rst);
        src_evt = 0; flag_clr = 0; wdt_tmo = 0; mode_req_vld = 0;
    endtask

    task automatic enter(input int md, input string tag);
        mode_req_vld = 1; mode_req = md[1:0];
        tick(tag);
    endtask

    task automatic fire(input bit [2:0] e, input bit [2:0] we, input bit [2:0] ie,
                        input bit g, input string tag);
        src_evt = e; src_wake_en = we; src_irq_en = ie; gie = g;
        tick(tag);
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: run hung, got 1 exp 0");
        summary();
        $finish;
    end

    initial begin
        rst_n = 0; mode_req_vld = 0; mode_req = 0; gie = 0;
        src_evt = 0; src_wake_en = 0; src_irq_en = 0; flag_clr = 0;
        wdt_en = 0; wdt_tmo = 0;
        @(negedge clk);
        repeat (3) tick("R1 reset");
        rst_n = 1;
        // R1: explicit reset state
        chk("R1 reset", "mode", mode, 0);
        chk("R1 reset", "clk_run", clk_run, 1);
        chk("R1 reset", "pend", pend, 0);
        chk("R1 reset", "strobes", {wake_pulse, redir_pulse, redir_is_rst}, 0);

        fire(3'b001, 3'b000, 3'b001, 1'b0, "R9 run adc flag no vector");
        fire(3'b100, 3'b000, 3'b100, 1'b1, "R9 run cmp vector");
        fire(3'b010, 3'b000, 3'b000, 1'b1, "R3 irq_en=0 no flag");
        flag_clr = 3'b001; tick("R4 clear adc");
        flag_clr = 3'b100; fire(3'b100, 3'b000, 3'b100, 1'b0, "R4 set beats clear");
        enter(3, "R2 code 3 ignored");
        enter(1, "R2 enter idle");
        enter(2, "R2 request outside run ignored");
        fire(3'b001, 3'b001, 3'b000, 1'b1, "R5 idle adc wake continue");
        tick("R5 single wake strobe");
        enter(2, "R2 enter sleep");
        fire(3'b010, 3'b010, 3'b010, 1'b1, "R8 pwm no wake from sleep");
        fire(3'b001, 3'b000, 3'b001, 1'b1, "R7 we=0 flag only");
        fire(3'b100, 3'b100, 3'b100, 1'b0, "R5 cmp wake gie=0 continue");
        enter(1, "R2 enter idle");
        fire(3'b010, 3'b010, 3'b010, 1'b1, "R8 R6 pwm wakes idle with vector");
        enter(2, "R2 enter sleep");
        fire(3'b100, 3'b100, 3'b100, 1'b1, "R6 cmp wake vector from sleep");
        wdt_en = 0; wdt_tmo = 1; tick("R10 wdt disabled ignored");
        enter(2, "R2 enter sleep");
        wdt_en = 1; wdt_tmo = 1; tick("R10 wdt wake reset");
        wdt_tmo = 1; fire(3'b101, 3'b101, 3'b101, 1'b1, "R11 wdt over vector, flags together");
        mode_req_vld = 1; mode_req = 2; fire(3'b001, 3'b000, 3'b001, 1'b1, "R2 entry dropped on redirect");

        for (int n = 0; n < 4000; n++) begin
            src_evt      = ($urandom % 4 == 0) ? 3'($urandom) : 3'b000;
            src_wake_en  = 3'($urandom);
            src_irq_en   = 3'($urandom);
            gie          = 1'($urandom);
            flag_clr     = ($urandom % 3 == 0) ? 3'($urandom) : 3'b000;
            wdt_en       = 1'($urandom);
            wdt_tmo      = ($urandom % 40 == 0);
            mode_req_vld = ($urandom % 5 == 0);
            mode_req     = 2'($urandom);
            tick("R11 random mix");
        end
        summary();
        $finish;
    end
endmodule